// File: doc/BRIEF.md
# Four-ary tree carry-lookahead adder

This block adds two N-bit operands and a carry-in with no registers. Each bit position first forms a propagate (`a XOR b`) and a generate (`a AND b`) bit. Groups of four such pairs are merged into one group pair by a four-input lookahead node. The node outputs are merged again by identical nodes, level by level, until one pair covers the whole word. The depth of this carry logic grows with log4 N.

Carries then travel back down the same tree. The root hands the carry-in to its four children. Each node takes the carry from its parent and forms the carries of its four children as flat sums of products. At the leaves, every sum bit is the bit propagate XOR its own carry.

The width parameter must be a power of four and at least four, such as 4, 16 or 64. The root group propagate and group generate are brought out as ports, so a wider adder can chain this block as one of its groups.

Top module: `cla_tree_adder`

## Requirements
- R1: `sumOut` equals the low N bits of `opA + opB + carryIn`, for every operand pair and either carry-in.
- R2: `carryOut` equals bit N (the bit just above the word) of `opA + opB + carryIn`.
- R3: `grpProp` is 1 exactly when `opA XOR opB` has every bit set, and it does not depend on `carryIn`.
- R4: `grpGen` is 1 exactly when `opA + opB` with no carry-in overflows N bits, and it does not depend on `carryIn`.
- R5: `grpProp` and `grpGen` are never 1 at the same time.
- R6: `carryOut` equals `grpGen OR (grpProp AND carryIn)`.
- R7: When every bit position propagates (`opB` is the bitwise inverse of `opA`) and `carryIn` is 1, the carry crosses the whole word: `sumOut` is all zeros and `carryOut` is 1. With `carryIn` 0 the same operands give an all-ones sum and `carryOut` 0.
- R8: The width parameter accepts any power of four from 4 upward. A four-bit instance (one tree level) and a 64-bit instance (three levels) both meet R1 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | N | First operand |
| opB | input | N | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | N | Sum modulo 2^N |
| carryOut | output | 1 | Carry out of the top bit |
| grpProp | output | 1 | Propagate of the whole word |
| grpGen | output | 1 | Generate of the whole word |

## Verification
The bound checker tests the arithmetic identities whenever any input changes. It compares sum and carry-out against a behavioural addition and root propagate against the bitwise XOR of the operands. It also checks that root generate agrees with a carry-free overflow, that the two root flags exclude each other, and that carry-out agrees with the root flags. These checks only fire on input patterns that actually occur. The bench's scenarios therefore supply the coverage: an exhaustive sweep of the four-bit instance, long propagate chains on the 64-bit instance in which a single carry-in must cross all three tree levels, near-chains broken at one bit, and random operands.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned RADIX = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } pgPair_t;

  // Associative lookahead operator: hi covers the more significant span.
  function automatic pgPair_t pgMerge(pgPair_t hi, pgPair_t lo);
    pgPair_t res;
    res.gen  = hi.gen | (hi.prop & lo.gen);
    res.prop = hi.prop & lo.prop;
    return res;
  endfunction

endpackage

// File: rtl/cla4_group.sv
module cla4_group
  import cla_pkg::*;
(
  input  logic [RADIX-1:0] pIn,
  input  logic [RADIX-1:0] gIn,
  output logic             pOut,
  output logic             gOut
);

  pgPair_t acc;

  always_comb begin
    acc = '{gen: gIn[0], prop: pIn[0]};
    for (int i = 1; i < RADIX; i++) begin
      acc = pgMerge('{gen: gIn[i], prop: pIn[i]}, acc);
    end
  end

  assign pOut = acc.prop;
  assign gOut = acc.gen;

endmodule

// File: rtl/cla4_carry.sv
module cla4_carry (
  input  logic [2:0] pIn,
  input  logic [2:0] gIn,
  input  logic       cIn,
  output logic [3:0] cOut
);

  // Flat two-level forms: no carry depends on a neighbouring carry output.
  assign cOut[0] = cIn;
  assign cOut[1] = gIn[0] | (pIn[0] & cIn);
  assign cOut[2] = gIn[1] | (pIn[1] & gIn[0]) | (pIn[1] & pIn[0] & cIn);
  assign cOut[3] = gIn[2] | (pIn[2] & gIn[1]) | (pIn[2] & pIn[1] & gIn[0])
                 | (pIn[2] & pIn[1] & pIn[0] & cIn);

endmodule

// File: rtl/cla_tree_adder.sv
module cla_tree_adder
  import cla_pkg::*;
#(
  parameter int unsigned N = 64
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  logic         carryIn,
  output logic [N-1:0] sumOut,
  output logic         carryOut,
  output logic         grpProp,
  output logic         grpGen
);

  localparam int unsigned LEVELS = $clog2(N) / 2;

  if (N < RADIX || N != (1 << (2 * LEVELS))) begin : widthCheck
    $error("cla_tree_adder: N must be a power of four, at least four");
  end

  // Upward sweep: level 0 holds bit pairs, level LEVELS holds the root.
  for (genvar k = 0; k <= LEVELS; k++) begin : lvl
    localparam int unsigned W = N >> (2 * k);
    logic [W-1:0] pUp;
    logic [W-1:0] gUp;
    if (k == 0) begin : leaf
      assign pUp = opA ^ opB;
      assign gUp = opA & opB;
    end else begin : node
      for (genvar j = 0; j < W; j++) begin : grp
        cla4_group uGroup (
          .pIn  (lvl[k-1].pUp[RADIX*j +: RADIX]),
          .gIn  (lvl[k-1].gUp[RADIX*j +: RADIX]),
          .pOut (pUp[j]),
          .gOut (gUp[j])
        );
      end
    end
  end

  // Downward sweep: carry into every node of level k, from its parent.
  for (genvar k = 0; k < LEVELS; k++) begin : dn
    localparam int unsigned W = N >> (2 * k);
    logic [W-1:0] cIn;
    for (genvar m = 0; m < W / RADIX; m++) begin : grp
      logic parentC;
      if (k == LEVELS - 1) begin : atRoot
        assign parentC = carryIn;
      end else begin : inner
        assign parentC = dn[k+1].cIn[m];
      end
      cla4_carry uCarry (
        .pIn  (lvl[k].pUp[RADIX*m +: 3]),
        .gIn  (lvl[k].gUp[RADIX*m +: 3]),
        .cIn  (parentC),
        .cOut (cIn[RADIX*m +: RADIX])
      );
    end
  end

  assign sumOut   = lvl[0].pUp ^ dn[0].cIn;
  assign grpProp  = lvl[LEVELS].pUp[0];
  assign grpGen   = lvl[LEVELS].gUp[0];
  assign carryOut = grpGen | (grpProp & carryIn);

endmodule

// File: rtl/cla_adder_checker.sv
module cla_adder_checker #(
  parameter int unsigned N = 64
) (
  input logic [N-1:0] opA,
  input logic [N-1:0] opB,
  input logic         carryIn,
  input logic [N-1:0] sumOut,
  input logic         carryOut,
  input logic         grpProp,
  input logic         grpGen
);

  logic [N:0] fullSum;
  logic [N:0] bareSum;

  always_comb begin
    fullSum = {1'b0, opA} + {1'b0, opB} + {{N{1'b0}}, carryIn};
    bareSum = {1'b0, opA} + {1'b0, opB};
  end

  always_comb begin
    AST_SUM_MATCH:   assert (sumOut == fullSum[N-1:0]);                // R1
    AST_COUT_MATCH:  assert (carryOut == fullSum[N]);                  // R2
    AST_ROOT_PROP:   assert (grpProp == (&(opA ^ opB)));               // R3
    AST_ROOT_GEN:    assert (grpGen == bareSum[N]);                    // R4
    AST_FLAGS_EXCL:  assert (!(grpProp && grpGen));                    // R5
    AST_COUT_FLAGS:  assert (carryOut == (grpGen | (grpProp & carryIn))); // R6
  end

endmodule

bind cla_tree_adder cla_adder_checker #(.N(N)) chk (.*);

// File: tb/tb_cla_tree_adder.sv
`timescale 1ns/1ps
module tb_cla_tree_adder;

  localparam int unsigned WIDE  = 64;
  localparam int unsigned SMALL = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [WIDE-1:0] a, b, s;
  logic            ci, co, gp, gg;
  logic [SMALL-1:0] sa, sb, ss;
  logic             sci, sco, sgp, sgg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  cla_tree_adder #(.N(WIDE)) dut (
    .opA(a), .opB(b), .carryIn(ci),
    .sumOut(s), .carryOut(co), .grpProp(gp), .grpGen(gg)
  );

  cla_tree_adder #(.N(SMALL)) dutSmall (
    .opA(sa), .opB(sb), .carryIn(sci),
    .sumOut(ss), .carryOut(sco), .grpProp(sgp), .grpGen(sgg)
  );

  task automatic check(input string tag, input logic [WIDE:0] act, input logic [WIDE:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkWide();
    logic [WIDE:0] full, bare;
    full = {1'b0, a} + {1'b0, b} + {{WIDE{1'b0}}, ci};
    bare = {1'b0, a} + {1'b0, b};
    check("R1 wide sum", {1'b0, s}, {1'b0, full[WIDE-1:0]});
    check("R2 wide carryOut", {{WIDE{1'b0}}, co}, {{WIDE{1'b0}}, full[WIDE]});
    check("R3 wide grpProp", {{WIDE{1'b0}}, gp}, {{WIDE{1'b0}}, ((a ^ b) == {WIDE{1'b1}})});
    check("R4 wide grpGen", {{WIDE{1'b0}}, gg}, {{WIDE{1'b0}}, bare[WIDE]});
    check("R5 wide flags exclusive", {{WIDE{1'b0}}, (gp & gg)}, '0);
    check("R6 wide carry from flags", {{WIDE{1'b0}}, co}, {{WIDE{1'b0}}, (gg | (gp & ci))});
  endtask

  task automatic checkSmall();
    int full, bare;
    full = int'(sa) + int'(sb) + int'(sci);
    bare = int'(sa) + int'(sb);
    check("R8 R1 small sum", {{(WIDE-SMALL+1){1'b0}}, ss}, (WIDE+1)'(full % 16));
    check("R8 R2 small carryOut", (WIDE+1)'(sco), (WIDE+1)'(full / 16));
    check("R8 R3 small grpProp", (WIDE+1)'(sgp), (WIDE+1)'((sa ^ sb) == 4'hF));
    check("R8 R4 small grpGen", (WIDE+1)'(sgg), (WIDE+1)'(bare >= 16));
    check("R8 R5 small exclusive", (WIDE+1)'(sgp & sgg), '0);
  endtask

  task automatic applyWide(input logic [WIDE-1:0] va, input logic [WIDE-1:0] vb, input logic vc);
    @(posedge clk);
    #1;
    a = va; b = vb; ci = vc;
    @(negedge clk);
    checkWide();
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0;
    sa = '0; sb = '0; sci = 1'b0;

    // R8: exhaustive sweep of the one-level instance
    for (int va = 0; va < 16; va++) begin
      for (int vb = 0; vb < 16; vb++) begin
        for (int vc = 0; vc < 2; vc++) begin
          @(posedge clk);
          #1;
          sa = 4'(va); sb = 4'(vb); sci = 1'(vc);
          @(negedge clk);
          checkSmall();
        end
      end
    end

    // Zero operands and all-ones operands
    applyWide('0, '0, 1'b0);
    check("R1 zero sum", {1'b0, s}, '0);
    applyWide({WIDE{1'b1}}, {WIDE{1'b1}}, 1'b1);
    check("R4 all ones generates", {{WIDE{1'b0}}, gg}, {{WIDE{1'b0}}, 1'b1});

    // R7: full-width propagate chain, both carry-in values
    for (int t = 0; t < 40; t++) begin
      logic [WIDE-1:0] r;
      r = {$urandom, $urandom};
      applyWide(r, ~r, 1'b1);
      check("R7 chain sum zero", {1'b0, s}, '0);
      check("R7 chain carryOut", {{WIDE{1'b0}}, co}, {{WIDE{1'b0}}, 1'b1});
      applyWide(r, ~r, 1'b0);
      check("R7 chain no carry sum", {1'b0, s}, {1'b0, {WIDE{1'b1}}});
      check("R7 chain no carry out", {{WIDE{1'b0}}, co}, '0);
    end

    // Chains broken at one bit position, each position in turn
    for (int pos = 0; pos < WIDE; pos++) begin
      logic [WIDE-1:0] r, m;
      r = {$urandom, $urandom};
      m = {{(WIDE-1){1'b0}}, 1'b1} << pos;
      applyWide(r, (~r) ^ m, 1'b1);
    end

    // Random operands
    for (int t = 0; t < 3000; t++) begin
      applyWide({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule